// File: doc/BRIEF.md
# Fetch-Address Breakpoint Watcher with ALE Pulse Counter

This block sits beside a target processor and watches the address the processor presents on each fetch. The host first arms a run by loading either eight soft breakpoint addresses with an enable mask, or one hard breakpoint address. While the run is active, the block compares the fetch address on every falling edge of the address-latch-enable strobe. On the first hit it raises a halt request towards the target and sends the byte 0xAA to the host. The host can end a run early by sending 0x55. In that case the target is halted and no byte is sent back.

Independently of any run, the block counts falling edges of the ALE strobe in a counter that is a whole number of bytes wide (32 bits by default). On command it sends the counter to the host, most significant byte first. A separate command clears the counter. Host bytes arrive one per cycle on a valid-qualified byte input. Bytes for the host leave on a one-cycle valid strobe with no back-pressure.

Top module: `brk_watch`

## Requirements
- R1: Command 0x0D starts a soft-breakpoint load. The next 16 bytes are the addresses, entry 0 first and entry 7 last, each given high byte then low byte. Then comes one enable byte. The run begins on the cycle after the enable byte is accepted.
- R2: Enable bit n (bit 0 = entry 0) arms soft entry n. An entry whose bit is clear never produces a match, whatever its address.
- R3: Command 0x0F starts a hard-breakpoint run. Two bytes follow, high byte then low byte. Only that address can match, and the soft entries have no effect in this mode.
- R4: A match during a run raises haltReq and emits exactly one byte 0xAA on txByte with txValid, one cycle after the clock edge at which the ALE fall is seen.
- R5: A host byte 0x55 during a run ends the run and raises haltReq. No byte is sent.
- R6: After a match or an abort, further matching fetches produce no byte and haltReq stays high. haltReq returns low when the last load byte of the next run is accepted.
- R7: Command 0x10 (outside a run) sends the counter on four consecutive cycles as bits 31..24, 23..16, 15..8, 7..0. The value sent is the count at the moment the command is accepted.
- R8: Command 0x11 (outside a run) sets the counter to zero.
- R9: The counter increments once per ALE falling edge and wraps from all ones to zero.
- R10: The fetch address is compared only at an ALE falling edge. A matching address held while ALE is steady low or steady high does not trigger.
- R11: During a run, any host byte other than 0x55 is ignored. Outside a run and outside a load, bytes that are not 0x0D, 0x0F, 0x10 or 0x11 are ignored.
- R12: After reset, haltReq and txValid are low and the counter reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address-latch-enable strobe of the target, synchronous to clk |
| fetchAddr | input | ADDR_W | Fetch address presented by the target |
| hostValid | input | 1 | hostByte carries a byte this cycle |
| hostByte | input | 8 | Command or data byte from the host |
| haltReq | output | 1 | Request that the target stop executing |
| txValid | output | 1 | txByte carries a byte for the host this cycle |
| txByte | output | 8 | Byte for the host |

## Verification
The assertions assume that ale is already synchronous to clk and holds each level for at least one cycle. They also assume the host never sends a byte while a counter burst is leaving, because such bytes are dropped. The bench drives ale and fetchAddr only at falling clock edges and holds every ALE level for at least a full cycle. It issues each command only after the previous reply has drained, and it mixes random breakpoint sets, enable masks and fetch addresses with directed cases for byte order, masking, steady ALE levels, abort and counter wrap.

// File: rtl/brk_watch_pkg.sv
package brk_watch_pkg;

  localparam logic [7:0] CMD_RUN_SOFT = 8'h0D;
  localparam logic [7:0] CMD_RUN_HARD = 8'h0F;
  localparam logic [7:0] CMD_CNT_READ = 8'h10;
  localparam logic [7:0] CMD_CNT_CLR  = 8'h11;
  localparam logic [7:0] CMD_ABORT    = 8'h55;
  localparam logic [7:0] MATCH_BYTE   = 8'hAA;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_RUN,
    ST_SEND
  } ctrlState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic shiftSoft;
    logic shiftHard;
    logic loadEn;
    logic clrCnt;
    logic snapCnt;
    logic sendMatch;
    logic sendCnt;
  } ctrlStrb_t;

endpackage

// File: rtl/brk_watch_ctrl.sv
module brk_watch_ctrl
  import brk_watch_pkg::*;
#(
  parameter int NUM_BP     = 8,
  parameter int ADDR_BYTES = 2,
  parameter int CNT_BYTES  = 4,
  localparam int CIDX_W    = $clog2(CNT_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostValid,
  input  logic [7:0]        hostByte,
  input  logic              aleFall,
  input  logic              hitSoft,
  input  logic              hitHard,
  output ctrlStrb_t         strb,
  output logic [CIDX_W-1:0] sendIdx,
  output logic              haltReq
);

  localparam int SOFT_BYTES = NUM_BP * ADDR_BYTES;
  localparam int MAX_IDX    = (SOFT_BYTES > CNT_BYTES) ? SOFT_BYTES : CNT_BYTES;
  localparam int IDX_W      = $clog2(MAX_IDX + 1);
  localparam logic [IDX_W-1:0] LAST_SOFT = IDX_W'(SOFT_BYTES);
  localparam logic [IDX_W-1:0] LAST_HARD = IDX_W'(ADDR_BYTES - 1);
  localparam logic [IDX_W-1:0] LAST_CNT  = IDX_W'(CNT_BYTES - 1);

  ctrlState_t state, stateNext;
  logic [IDX_W-1:0] idx, idxNext;
  logic modeSoft, modeNext;
  logic haltNext;
  logic runHit;

  assign runHit  = aleFall && (modeSoft ? hitSoft : hitHard);
  assign sendIdx = idx[CIDX_W-1:0];

  always_comb begin
    strb      = '0;
    stateNext = state;
    idxNext   = idx;
    modeNext  = modeSoft;
    haltNext  = haltReq;
    case (state)
      ST_IDLE: begin
        if (hostValid) begin
          case (hostByte)
            CMD_RUN_SOFT: begin
              stateNext = ST_LOAD;
              modeNext  = 1'b1;
              idxNext   = '0;
            end
            CMD_RUN_HARD: begin
              stateNext = ST_LOAD;
              modeNext  = 1'b0;
              idxNext   = '0;
            end
            CMD_CNT_READ: begin
              stateNext    = ST_SEND;
              idxNext      = '0;
              strb.snapCnt = 1'b1;
            end
            CMD_CNT_CLR: strb.clrCnt = 1'b1;
            default: ;
          endcase
        end
      end
      ST_LOAD: begin
        if (hostValid) begin
          if (modeSoft) begin
            if (idx == LAST_SOFT) begin
              strb.loadEn = 1'b1;
              stateNext   = ST_RUN;
              haltNext    = 1'b0;
            end else begin
              strb.shiftSoft = 1'b1;
              idxNext        = idx + 1'b1;
            end
          end else begin
            strb.shiftHard = 1'b1;
            idxNext        = idx + 1'b1;
            if (idx == LAST_HARD) begin
              stateNext = ST_RUN;
              haltNext  = 1'b0;
            end
          end
        end
      end
      ST_RUN: begin
        // a match in the same cycle as an abort byte wins and is reported
        if (runHit) begin
          strb.sendMatch = 1'b1;
          haltNext       = 1'b1;
          stateNext      = ST_IDLE;
        end else if (hostValid && hostByte == CMD_ABORT) begin
          haltNext  = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      ST_SEND: begin
        strb.sendCnt = 1'b1;
        idxNext      = idx + 1'b1;
        if (idx == LAST_CNT) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      idx      <= '0;
      modeSoft <= 1'b0;
      haltReq  <= 1'b0;
    end else begin
      state    <= stateNext;
      idx      <= idxNext;
      modeSoft <= modeNext;
      haltReq  <= haltNext;
    end
  end

endmodule

// File: rtl/brk_watch_dpath.sv
module brk_watch_dpath
  import brk_watch_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_BP    = 8,
  parameter int CNT_BYTES = 4,
  localparam int CIDX_W   = $clog2(CNT_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ale,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [7:0]        hostByte,
  input  ctrlStrb_t         strb,
  input  logic [CIDX_W-1:0] sendIdx,
  output logic              aleFall,
  output logic              hitSoft,
  output logic              hitHard,
  output logic              txValid,
  output logic [7:0]        txByte
);

  localparam int CHAIN_W = NUM_BP * ADDR_W;
  localparam int CNT_W   = 8 * CNT_BYTES;

  logic                aleQ;
  logic [CHAIN_W-1:0]  softChain;
  logic [ADDR_W-1:0]   hardAddr;
  logic [NUM_BP-1:0]   bpEn;
  logic [NUM_BP-1:0]   hitVec;
  logic [CNT_W-1:0]    aleCount;
  logic [CNT_W-1:0]    countSnap;

  assign aleFall = aleQ && !ale;

  // soft addresses shift in a byte at a time; entry 0 ends at the top
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aleQ      <= 1'b0;
      softChain <= '0;
      hardAddr  <= '0;
      bpEn      <= '0;
    end else begin
      aleQ <= ale;
      if (strb.shiftSoft) softChain <= {softChain[CHAIN_W-9:0], hostByte};
      if (strb.shiftHard) hardAddr  <= {hardAddr[ADDR_W-9:0], hostByte};
      if (strb.loadEn)    bpEn      <= hostByte[NUM_BP-1:0];
    end
  end

  generate
    for (genvar i = 0; i < NUM_BP; i++) begin : g_cmp
      assign hitVec[i] = bpEn[i] &&
        (softChain[(NUM_BP-i)*ADDR_W-1 -: ADDR_W] == fetchAddr);
    end
  endgenerate

  assign hitSoft = |hitVec;
  assign hitHard = (hardAddr == fetchAddr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aleCount  <= '0;
      countSnap <= '0;
    end else begin
      if (strb.clrCnt)  aleCount <= '0;
      else if (aleFall) aleCount <= aleCount + 1'b1;
      if (strb.snapCnt) countSnap <= aleCount;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txValid <= 1'b0;
      txByte  <= '0;
    end else begin
      txValid <= strb.sendMatch || strb.sendCnt;
      if (strb.sendMatch)
        txByte <= MATCH_BYTE;
      else if (strb.sendCnt)
        txByte <= countSnap[8*(CNT_BYTES-1-int'(sendIdx)) +: 8];
    end
  end

endmodule

// File: rtl/brk_watch.sv
module brk_watch
  import brk_watch_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_BP    = 8,
  parameter int CNT_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ale,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              hostValid,
  input  logic [7:0]        hostByte,
  output logic              haltReq,
  output logic              txValid,
  output logic [7:0]        txByte
);

  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int CIDX_W     = $clog2(CNT_BYTES + 1);

  ctrlStrb_t         strb;
  logic [CIDX_W-1:0] sendIdx;
  logic              aleFall;
  logic              hitSoft;
  logic              hitHard;

  brk_watch_ctrl #(
    .NUM_BP     (NUM_BP),
    .ADDR_BYTES (ADDR_BYTES),
    .CNT_BYTES  (CNT_BYTES)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .hostValid (hostValid),
    .hostByte  (hostByte),
    .aleFall   (aleFall),
    .hitSoft   (hitSoft),
    .hitHard   (hitHard),
    .strb      (strb),
    .sendIdx   (sendIdx),
    .haltReq   (haltReq)
  );

  brk_watch_dpath #(
    .ADDR_W    (ADDR_W),
    .NUM_BP    (NUM_BP),
    .CNT_BYTES (CNT_BYTES)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .ale       (ale),
    .fetchAddr (fetchAddr),
    .hostByte  (hostByte),
    .strb      (strb),
    .sendIdx   (sendIdx),
    .aleFall   (aleFall),
    .hitSoft   (hitSoft),
    .hitHard   (hitHard),
    .txValid   (txValid),
    .txByte    (txByte)
  );

endmodule

// File: rtl/brk_watch_chk.sv
module brk_watch_chk
  import brk_watch_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       ale,
  input logic       haltReq,
  input logic       txValid,
  input logic [7:0] txByte,
  input ctrlStrb_t  strb
);

  // R4: a reported hit shows up as 0xAA with the halt raised
  p_match_byte_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.sendMatch |=> (txValid && txByte == MATCH_BYTE && haltReq));

  // R6: no second report while the target is held
  p_single_report_r6: assert property (@(posedge clk) disable iff (!rstN)
    haltReq |-> !strb.sendMatch);

  // R10: a hit is only taken at a falling ALE edge
  p_fall_sample_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.sendMatch |-> (!ale && $past(ale)));

  // R7: the first counter byte leaves two cycles after the command edge
  p_read_burst_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.snapCnt |-> ##2 txValid);

  // R8: clearing the counter sends nothing
  p_clear_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrCnt |=> !txValid);

endmodule

bind brk_watch brk_watch_chk chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .ale     (ale),
  .haltReq (haltReq),
  .txValid (txValid),
  .txByte  (txByte),
  .strb    (strb)
);

// File: tb/brk_watch_tb_top.sv
module brk_watch_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        ale;
  logic [15:0] fetchAddr;
  logic        hostValid, hostValid8;
  logic [7:0]  hostByte, hostByte8;
  logic        haltReq, halt8;
  logic        txValid, tx8Valid;
  logic [7:0]  txByte, tx8Byte;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int aleModel = 0;
  logic [7:0] rxq[$];
  int         rxc[$];
  logic [7:0] rx8q[$];
  logic [15:0] bpA[8];
  logic [7:0]  bpE;

  always #(CLK_PERIOD/2) clk = ~clk;

  brk_watch dut_i (
    .clk(clk), .rstN(rstN), .ale(ale), .fetchAddr(fetchAddr),
    .hostValid(hostValid), .hostByte(hostByte),
    .haltReq(haltReq), .txValid(txValid), .txByte(txByte));

  brk_watch #(.CNT_BYTES(1)) dut8_i (
    .clk(clk), .rstN(rstN), .ale(ale), .fetchAddr(fetchAddr),
    .hostValid(hostValid8), .hostByte(hostByte8),
    .haltReq(halt8), .txValid(tx8Valid), .txByte(tx8Byte));

  always @(negedge clk) begin
    cyc++;
    if (txValid) begin rxq.push_back(txByte); rxc.push_back(cyc); end
    if (tx8Valid) rx8q.push_back(tx8Byte);
  end

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    hostByte = b; hostValid = 1'b1;
    @(negedge clk);
    hostValid = 1'b0;
  endtask

  task automatic send8(input logic [7:0] b);
    hostByte8 = b; hostValid8 = 1'b1;
    @(negedge clk);
    hostValid8 = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] a);
    fetchAddr = a; ale = 1'b1;
    @(negedge clk);
    ale = 1'b0;
    @(negedge clk);
    aleModel++;
  endtask

  task automatic loadSoft();
    send(8'h0D);
    for (int i = 0; i < 8; i++) begin
      send(bpA[i][15:8]);
      send(bpA[i][7:0]);
    end
    send(bpE);
  endtask

  task automatic loadHard(input logic [15:0] a);
    send(8'h0F); send(a[15:8]); send(a[7:0]);
  endtask

  function automatic bit expHit(input logic [15:0] a);
    for (int i = 0; i < 8; i++)
      if (bpE[i] && bpA[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  // collect whatever the design sent since the last clear
  task automatic expectRx(input string tag, input int n);
    idle(2);
    check(rxq.size() == n, tag, rxq.size(), n);
    for (int i = 0; i < rxq.size(); i++)
      check(rxq[i] == 8'hAA, tag, rxq[i], 8'hAA);
    rxq.delete(); rxc.delete();
  endtask

  task automatic readCnt(input string tag, input logic [31:0] exp);
    logic [31:0] v;
    rxq.delete(); rxc.delete();
    send(8'h10);
    idle(6);
    check(rxq.size() == 4, tag, rxq.size(), 4);
    if (rxq.size() == 4) begin
      v = {rxq[0], rxq[1], rxq[2], rxq[3]};
      check(v == exp, tag, v, exp);
      check(rxc[3] - rxc[0] == 3, {tag, " consecutive"}, rxc[3] - rxc[0], 3);
    end
    rxq.delete(); rxc.delete();
  endtask

  task automatic read8(input string tag, input logic [7:0] exp);
    rx8q.delete();
    send8(8'h10);
    idle(4);
    check(rx8q.size() == 1, tag, rx8q.size(), 1);
    if (rx8q.size() == 1) check(rx8q[0] == exp, tag, rx8q[0], exp);
    rx8q.delete();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL R12 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit hitSeen;
    logic [15:0] a;
    void'($urandom(32'd20240611));
    rstN = 1'b0; ale = 1'b0; fetchAddr = '0;
    hostValid = 1'b0; hostByte = '0; hostValid8 = 1'b0; hostByte8 = '0;
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R12 reset state
    check(haltReq == 1'b0, "R12 haltReq", haltReq, 0);
    check(txValid == 1'b0, "R12 txValid", txValid, 0);
    readCnt("R12 counter", 0);

    // R1 byte and entry order: only entry 7 armed
    for (int i = 0; i < 8; i++) bpA[i] = {8'h10 + 8'(i), 8'hA0 + 8'(i)};
    bpE = 8'h80;
    loadSoft();
    check(haltReq == 1'b0, "R6 halt low after load", haltReq, 0);
    pulse(16'hA717);
    expectRx("R1 swapped bytes no hit", 0);
    pulse(16'h10A0);
    expectRx("R1 entry 0 not armed", 0);
    pulse(16'h17A7);
    expectRx("R1 entry 7 hit", 1);
    check(haltReq == 1'b1, "R4 halt on hit", haltReq, 1);

    // R2 mask, R10 steady levels, R6 single report
    bpE = 8'h04;
    loadSoft();
    check(haltReq == 1'b0, "R6 halt released on new run", haltReq, 0);
    pulse(bpA[0]); pulse(bpA[7]);
    expectRx("R2 disabled entries", 0);
    fetchAddr = bpA[2]; ale = 1'b0; idle(4);
    expectRx("R10 steady low", 0);
    ale = 1'b1; idle(3);
    expectRx("R10 steady high", 0);
    ale = 1'b0; idle(1); aleModel++;
    expectRx("R4 hit at fall", 1);
    pulse(bpA[2]);
    expectRx("R6 no second report", 0);
    check(haltReq == 1'b1, "R6 halt held", haltReq, 1);

    // R3 hard mode ignores soft entries
    loadHard(16'h1234);
    pulse(16'h3412); pulse(bpA[2]);
    expectRx("R3 non-matching", 0);
    // R11 bytes ignored during run
    send(8'h10); send(8'h0D); send(8'h11);
    expectRx("R11 run ignores bytes", 0);
    check(haltReq == 1'b0, "R11 still running", haltReq, 0);
    pulse(16'h1234);
    expectRx("R3 hard hit", 1);

    // R5 abort
    loadHard(16'hBEEF);
    send(8'h55);
    expectRx("R5 abort silent", 0);
    check(haltReq == 1'b1, "R5 halt after abort", haltReq, 1);
    pulse(16'hBEEF);
    expectRx("R5 run ended", 0);
    send(8'h77);
    expectRx("R11 idle unknown byte", 0);

    // random soft runs
    for (int t = 0; t < 20; t++) begin
      for (int i = 0; i < 8; i++) bpA[i] = 16'($urandom);
      bpE = 8'($urandom);
      loadSoft();
      hitSeen = 1'b0;
      for (int j = 0; j < 6; j++) begin
        a = ($urandom % 3 == 0) ? bpA[$urandom % 8] : 16'($urandom);
        if (!hitSeen && expHit(a)) hitSeen = 1'b1;
        pulse(a);
      end
      expectRx("R2 random run", hitSeen ? 1 : 0);
      check(haltReq == hitSeen, "R4 random halt", haltReq, hitSeen);
      send(8'h55);
      check(haltReq == 1'b1, "R5 random abort", haltReq, 1);
      expectRx("R5 random abort silent", 0);
    end

    // R9 wrap on the one-byte variant
    send8(8'h11);
    idle(1);
    for (int k = 0; k < 255; k++) pulse(16'h0000);
    read8("R9 all ones", 8'hFF);
    pulse(16'h0000);
    read8("R9 wrap to zero", 8'h00);

    // R7 read, R8 clear
    readCnt("R7 counter value", 32'(aleModel));
    send(8'h11);
    readCnt("R8 cleared", 0);
    pulse(16'h0001); pulse(16'h0002);
    readCnt("R9 count after clear", 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule